// File: doc/BRIEF.md
# Pixel Raster Operation Unit

This block combines one destination pixel with one operand pixel under an 8-bit raster-operation code and writes out the new destination pixel. It is the arithmetic heart of a 2D blitter: the address walker and memory port around it feed it one pixel per accepted transfer and collect one result per transfer. The operand is either a plain source pixel or a pattern pixel. A table-select input picks which of the two code sets applies. In the pattern set, one extra code is a three-operand select. That code takes a third operand: the non-pattern source, used as a per-bit mask.

Each pixel carries its own depth selector (8, 15, 16 or 24 bits per pixel). The result is confined to the active bits of that depth. All destination bits above the active field are passed on from the input destination, so the spare top bit of a 15-bit pixel and the top byte of a 24-bit word are never altered. A code that belongs to neither table leaves the pixel as it was. It also sets a sticky error flag that only reset clears. A single register stage with a valid/ready handshake sits between the combiner and the output.

Top module: `rop_pixel_unit`

## Requirements
- R1: With `in_pat`=0, a code is valid when its upper nibble equals its lower nibble, n. Each result bit i is then n[2*S[i]+D[i]], where S is `in_src` and D is `in_dst`.
- R2: With `in_pat`=1, a code other than 0xB8 is valid when code[k] equals code[k XOR 2] for every k. Each result bit i is then code[4*P[i]+D[i]], where P is `in_src`.
- R3: With `in_pat`=1 and code 0xB8, each result bit takes D where `in_aux` is 1 and takes P where `in_aux` is 0.
- R4: Code 0xAA returns the destination unmodified under either table.
- R5: An invalid code returns `in_dst` unmodified and sets `illegal_rop`. The flag stays set until reset.
- R6: `in_depth` encodes 0=8, 1=15, 2=16 and 3=24 bits per pixel, with an active field of bits [w-1:0]. Bits w and above of the result always equal the same bits of `in_dst`.
- R7: Code 0xFF sets every active bit at the selected depth and no other bit.
- R8: Depth is taken with each pixel, so back-to-back pixels with different depths are each processed at their own depth with no idle cycle between them.
- R9: `in_ready` is high when the output stage is empty or is being drained. The result of an accepted pixel is presented on `out_pix` with `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, `out_pix` holds its value.
- R10: After reset `out_valid` and `illegal_rop` are 0. `in_ready` rises within three cycles of reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Input pixel can be taken |
| in_dst | input | WORD_W | Destination pixel word |
| in_src | input | WORD_W | Source or pattern operand |
| in_aux | input | WORD_W | Non-pattern source mask for the select code |
| in_code | input | 8 | Raster-operation code |
| in_pat | input | 1 | 1 selects the pattern code set |
| in_depth | input | 2 | Pixel depth selector |
| out_valid | output | 1 | Result pixel present |
| out_ready | input | 1 | Consumer takes the result |
| out_pix | output | WORD_W | Result pixel word |
| illegal_rop | output | 1 | Sticky flag for an invalid code |

## Verification
The bench builds the unit with its default 32-bit word. This leaves eight destination bits above the widest 24-bit field, so carry-through of the upper bits can be seen at every depth. It also leaves seventeen bits above the 15-bit field, and the spare bit 15 can be seen on its own. All 256 codes are run under both tables at all four depths, while the consumer stalls in a repeating pattern. This exercises the full valid and invalid code space, together with back-pressure and per-pixel depth changes.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int PIX8_W  = 8;
  localparam int PIX15_W = 15;
  localparam int PIX16_W = 16;
  localparam int PIX24_W = 24;

  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_15 = 2'd1,
    DEPTH_16 = 2'd2,
    DEPTH_24 = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    OPK_TABLE  = 2'd0,
    OPK_SELECT = 2'd1,
    OPK_KEEP   = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [3:0] fn;     // truth table indexed by {operand, dst}
    logic       legal;
  } rop_ctrl_t;
endpackage

// File: rtl/rop_decode.sv
module rop_decode
  import rop_pkg::*;
(
  input  logic [7:0] code,
  input  logic       pat,
  output rop_ctrl_t  ctrl
);
  logic plain_ok;
  logic pat_ok;

  assign plain_ok = (code[7:4] == code[3:0]);
  assign pat_ok   = (code[2] == code[0]) && (code[3] == code[1]) &&
                    (code[6] == code[4]) && (code[7] == code[5]);

  always_comb begin
    ctrl.kind  = OPK_KEEP;
    ctrl.fn    = 4'hA;
    ctrl.legal = 1'b0;
    if (!pat) begin
      if (plain_ok) begin
        ctrl.kind  = OPK_TABLE;
        ctrl.fn    = code[3:0];
        ctrl.legal = 1'b1;
      end
    end else if (code == 8'hB8) begin
      ctrl.kind  = OPK_SELECT;
      ctrl.legal = 1'b1;
    end else if (pat_ok) begin
      ctrl.kind  = OPK_TABLE;
      ctrl.fn    = {code[5], code[4], code[1], code[0]};
      ctrl.legal = 1'b1;
    end
  end
endmodule

// File: rtl/rop_logic.sv
module rop_logic
  import rop_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  op_kind_e          kind,
  input  logic [3:0]        fn,
  input  logic [WORD_W-1:0] opnd,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] aux,
  output logic [WORD_W-1:0] res
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    always_comb begin
      case (kind)
        OPK_TABLE:  res[i] = fn[{opnd[i], dst[i]}];
        OPK_SELECT: res[i] = aux[i] ? dst[i] : opnd[i];
        default:    res[i] = dst[i];
      endcase
    end
  end
endmodule

// File: rtl/depth_merge.sv
module depth_merge
  import rop_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  depth_e            depth,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] merged
);
  localparam logic [WORD_W-1:0] MASK8  = {{(WORD_W-PIX8_W){1'b0}},  {PIX8_W{1'b1}}};
  localparam logic [WORD_W-1:0] MASK15 = {{(WORD_W-PIX15_W){1'b0}}, {PIX15_W{1'b1}}};
  localparam logic [WORD_W-1:0] MASK16 = {{(WORD_W-PIX16_W){1'b0}}, {PIX16_W{1'b1}}};
  localparam logic [WORD_W-1:0] MASK24 = {{(WORD_W-PIX24_W){1'b0}}, {PIX24_W{1'b1}}};

  logic [WORD_W-1:0] mask;

  always_comb begin
    case (depth)
      DEPTH_8:  mask = MASK8;
      DEPTH_15: mask = MASK15;
      DEPTH_16: mask = MASK16;
      default:  mask = MASK24;
    endcase
  end

  assign merged = (raw & mask) | (dst & ~mask);
endmodule

// File: rtl/rop_pixel_unit.sv
module rop_pixel_unit
  import rop_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_dst,
  input  logic [WORD_W-1:0] in_src,
  input  logic [WORD_W-1:0] in_aux,
  input  logic [7:0]        in_code,
  input  logic              in_pat,
  input  logic [1:0]        in_depth,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_pix,
  output logic              illegal_rop
);
  rop_ctrl_t         ctrl;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] merged;
  logic [1:0]        rst_sync_q;
  logic              run;
  logic              accept;
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] pix_q, pix_d;
  logic              flag_q, flag_d;

  rop_decode u_dec (
    .code (in_code),
    .pat  (in_pat),
    .ctrl (ctrl)
  );

  rop_logic #(.WORD_W(WORD_W)) u_logic (
    .kind (ctrl.kind),
    .fn   (ctrl.fn),
    .opnd (in_src),
    .dst  (in_dst),
    .aux  (in_aux),
    .res  (raw)
  );

  depth_merge #(.WORD_W(WORD_W)) u_merge (
    .depth  (depth_e'(in_depth)),
    .dst    (in_dst),
    .raw    (raw),
    .merged (merged)
  );

  // reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  assign in_ready = run && (!valid_q || out_ready);
  assign accept   = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    pix_d   = pix_q;
    flag_d  = flag_q;
    if (accept) begin
      valid_d = 1'b1;
      pix_d   = merged;
      flag_d  = flag_q | ~ctrl.legal;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      flag_q  <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pix_q <= '0;
    else if (accept) pix_q <= pix_d;
  end

  assign out_valid   = valid_q;
  assign out_pix     = pix_q;
  assign illegal_rop = flag_q;
endmodule

// File: rtl/rop_pixel_checker.sv
module rop_pixel_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_dst,
  input logic [7:0]        in_code,
  input logic [1:0]        in_depth,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_pix,
  input logic              illegal_rop
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R9
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R9
  AST_KEEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_code == 8'hAA |=> out_pix == $past(in_dst)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rop |=> illegal_rop); // R5
  AST_TOP_BYTE_24: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_depth == 2'd3 |=> out_pix[WORD_W-1:24] == $past(in_dst[WORD_W-1:24])); // R6
  AST_SPARE_BIT_15: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_depth == 2'd1 |=> out_pix[WORD_W-1:15] == $past(in_dst[WORD_W-1:15])); // R6
endmodule

bind rop_pixel_unit rop_pixel_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_dst      (in_dst),
  .in_code     (in_code),
  .in_depth    (in_depth),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_pix     (out_pix),
  .illegal_rop (illegal_rop)
);

// File: tb/sim_rop_pixel_unit.sv
`timescale 1ns/1ps
module sim_rop_pixel_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dst = '0;
  logic [W-1:0] in_src = '0;
  logic [W-1:0] in_aux = '0;
  logic [7:0]   in_code = '0;
  logic         in_pat = 1'b0;
  logic [1:0]   in_depth = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_pix;
  logic         illegal_rop;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stall_mode = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  rop_pixel_unit #(.WORD_W(W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int act_w(input logic [1:0] dp);
    case (dp)
      2'd0: return 8;
      2'd1: return 15;
      2'd2: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic bit code_ok(input logic [7:0] c, input bit p);
    if (!p) return c[7:4] == c[3:0];
    if (c == 8'hB8) return 1'b1;
    for (int k = 0; k < 8; k++) if (c[k] != c[k ^ 2]) return 1'b0;
    return 1'b1;
  endfunction

  // expected value built from R1, R2, R3, R5, R6
  function automatic logic [W-1:0] model(input logic [W-1:0] d, s, a,
                                          input logic [7:0] c, input bit p, input logic [1:0] dp);
    logic [W-1:0] r = d;
    if (!code_ok(c, p)) return d;
    for (int i = 0; i < act_w(dp); i++) begin
      if (!p)            r[i] = c[2*s[i] + d[i]];
      else if (c == 8'hB8) r[i] = a[i] ? d[i] : s[i];
      else               r[i] = c[4*s[i] + d[i]];
    end
    return r;
  endfunction

  // called at posedge+1; returns at posedge+1 after acceptance
  task automatic send(input logic [W-1:0] d, s, a, input logic [7:0] c, input bit p,
                      input logic [1:0] dp, input logic [W-1:0] exp, input string req);
    in_dst = d; in_src = s; in_aux = a; in_code = c; in_pat = p; in_depth = dp;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // monitor
  initial begin
    logic [W-1:0] held;
    bit held_v = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held_v && out_valid) chk(out_pix == held, "R9 hold", out_pix, held);
        held_v = out_valid && !out_ready;
        held = out_pix;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R9 extra", out_pix, '0);
          else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_pix == e, t, out_pix, e);
          end
        end
      end
    end
  end

  // consumer back-pressure
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      cyc++;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid", W'(out_valid), '0);
    chk(illegal_rop == 1'b0, "R10 flag", W'(illegal_rop), '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready", W'(in_ready), 1);
    @(posedge clk); #1;

    send(32'hAABBCC3C, 32'h000000F0, '0, 8'h66, 0, 2'd0, 32'hAABBCCCC, "R1 xor 8bpp");
    send(32'h00000F0F, 32'h000000FF, '0, 8'h5A, 1, 2'd2, 32'h00000FF0, "R2 pat xor 16bpp");
    send(32'h11223300, 32'h0000003C, '0, 8'h0F, 1, 2'd0, 32'h112233C3, "R2 not pat 8bpp");
    send(32'h77AAAAAA, 32'h00555555, 32'h00FF00F0, 8'hB8, 1, 2'd3, 32'h77AA55A5, "R3 select 24bpp");
    send(32'h9ABCDEF0, 32'h12345678, '0, 8'hAA, 0, 2'd3, 32'h9ABCDEF0, "R4 plain keep");
    send(32'h0F1E2D3C, 32'hFFFFFFFF, '0, 8'hAA, 1, 2'd2, 32'h0F1E2D3C, "R4 pat keep");
    send(32'h12340000, '0, '0, 8'hFF, 0, 2'd2, 32'h1234FFFF, "R7 ones 16bpp");
    send(32'h12340000, '0, '0, 8'hFF, 1, 2'd1, 32'h12347FFF, "R7 ones 15bpp");
    send(32'h5A000000, '0, '0, 8'hFF, 0, 2'd3, 32'h5AFFFFFF, "R7 ones 24bpp");
    send(32'h12345600, '0, '0, 8'hFF, 1, 2'd0, 32'h123456FF, "R7 ones 8bpp");
    send(32'h00008000, 32'hFFFFFFFF, '0, 8'hCC, 0, 2'd1, 32'h0000FFFF, "R6 copy 15bpp bit15");
    send(32'hC3000000, 32'hFFFFFFFF, '0, 8'h33, 0, 2'd3, 32'hC3000000, "R6 not src 24bpp");
    drain();
    @(negedge clk);
    chk(illegal_rop == 1'b0, "R5 flag clear after legal codes", W'(illegal_rop), '0);
    @(posedge clk); #1;
    send(32'hDEADBEEF, 32'h01234567, '0, 8'h12, 0, 2'd3, 32'hDEADBEEF, "R5 illegal plain");
    send(32'hCAFEF00D, 32'h01234567, '0, 8'hB8, 0, 2'd0, 32'hCAFEF00D, "R5 plain B8 illegal");
    send(32'h0BADC0DE, 32'h76543210, '0, 8'h11, 1, 2'd2, 32'h0BADC0DE, "R5 illegal pattern");
    drain();
    @(negedge clk);
    chk(illegal_rop == 1'b1, "R5 flag set", W'(illegal_rop), 1);
    @(posedge clk); #1;

    // R8: back-to-back depth changes, then full sweep under stalls
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] d = 32'h13579BDF * (k + 1);
      logic [W-1:0] s = 32'h2468ACE1 ^ (k << 5);
      send(d, s, '0, 8'hEE, 0, 2'(k), model(d, s, '0, 8'hEE, 0, 2'(k)), "R8 depth switch");
    end
    stall_mode = 1;
    for (int c = 0; c < 256; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int dp = 0; dp < 4; dp++) begin
          logic [W-1:0] d = 32'h9E3779B9 * (c * 8 + p * 4 + dp + 1);
          logic [W-1:0] s = 32'h85EBCA6B ^ (d << 3) ^ W'(c);
          logic [W-1:0] a = 32'hC2B2AE35 ^ (s >> 2);
          send(d, s, a, 8'(c), p[0], 2'(dp), model(d, s, a, 8'(c), p[0], 2'(dp)),
               p ? "R2 R3 pattern sweep" : "R1 plain sweep");
        end
      end
    end
    stall_mode = 0;
    drain();
    rst_n = 1'b0;
    @(negedge clk);
    chk(illegal_rop == 1'b0, "R10 flag cleared by reset", W'(illegal_rop), '0);
    chk(out_valid == 1'b0, "R10 valid after reset", W'(out_valid), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule